// File: doc/BRIEF.md
# RTC Frequency Trim Unit

This block sits between a 32.768 kHz timekeeping pulse source and the seconds counter that consumes it. It counts source pulses into correction windows of either 20 or 60 seconds. At the start of each window it drops or inserts a programmed number of tick enables, so that the count of ticks over the window is stretched or shrunk by a fixed amount. The result cancels crystal drift in steps of two pulses per window. With the long window each step is worth roughly one part per million. With the short window each step is worth roughly three parts per million.

Software writes an 8-bit trim word. Bit 7 picks the window length. Bit 6 picks the direction. Bits 5:0 carry a step code. Positive corrections use a code biased by one, and negative corrections use a ones-complement code. An accepted write raises a busy flag and is parked until the next window boundary, where it becomes the active trim. The busy flag then drops. Writes made while the flag is high are discarded.

The source is a single-cycle enable `src_pulse_i` in the block's clock domain. Two pulses must be separated by at least one idle cycle, and inserted ticks are placed in those idle cycles.

Top module: `rtc_trim_unit`

## Requirements
- R1: While `rst_i` is high and on the first cycle after it, `tick_o` and `busy_o` are 0 and the active trim word is 0x00.
- R2: A window holds PULSES_PER_SEC × LONG_S source pulses when bit 7 of the active trim is 1, and PULSES_PER_SEC × SHORT_S pulses when bit 7 is 0. The boundary is the last pulse of a window.
- R3: A step code (bits 5:0) of zero applies no correction, whatever bits 7 and 6 hold. In that case every source pulse gives exactly one tick.
- R4: With bit 6 = 0 (add), the step count is code − 1, and the window gets 2 × steps extra ticks. Code 1 adds nothing, and code 63 adds 124 ticks.
- R5: With bit 6 = 1 (remove), the step count is (bitwise inverse of the 6-bit code) + 1, and 2 × steps source pulses are suppressed. Code 63 removes 2 ticks, and code 1 removes 126 ticks.
- R6: A write while `busy_o` is 0 sets `busy_o` on the next cycle. `busy_o` stays set until the next window boundary, clears on the cycle after it, and the written word governs the window that starts there.
- R7: A write while `busy_o` is 1 is discarded and never becomes active.
- R8: `tick_o` follows a sampled source pulse by one cycle. An inserted tick appears only one cycle after a cycle without a source pulse. No tick is produced when there is no source pulse and no pending insertion.
- R9: The corrections for a window are made at its start and are finished by its boundary. The tick total of each window therefore equals its pulse count plus or minus 2 × steps of the trim active in it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Block clock |
| rst_i | input | 1 | Synchronous active-high reset |
| src_pulse_i | input | 1 | One-cycle enable per 32.768 kHz source pulse |
| wr_en_i | input | 1 | Trim word write strobe |
| wr_data_i | input | 8 | Trim word: [7] long window, [6] remove, [5:0] step code |
| tick_o | output | 1 | Corrected tick enable for the seconds counter |
| busy_o | output | 1 | High while a written trim word waits for a window boundary |

## Verification
The bench builds the block with PULSES_PER_SEC = 8, SHORT_S = 20 and LONG_S = 60. This gives windows of 160 and 480 pulses, with a source pulse every fourth clock. With these values a simulation can run a dozen whole windows, which brings the extreme codes within reach: 126 removed ticks take up most of a short window, and 124 inserted ticks fill idle cycles in a long one. Over the same windows the bench can check each tick total exactly, and can check the one-window lag between a write and the window it governs.

// File: rtl/rtc_trim_pkg.sv
package rtc_trim_pkg;

    localparam int unsigned CODE_W  = 6;
    localparam int unsigned PEND_W  = CODE_W + 1;

    typedef struct packed {
        logic              long_win;
        logic              remove;
        logic [CODE_W-1:0] code;
    } trim_word_t;

    typedef enum logic [1:0] {
        ADJ_NONE = 2'd0,
        ADJ_ADD  = 2'd1,
        ADJ_DROP = 2'd2
    } adj_mode_t;

    typedef struct packed {
        adj_mode_t         mode;
        logic [CODE_W-1:0] steps;
    } trim_cmd_t;

    function automatic trim_cmd_t decode_trim(input trim_word_t w);
        trim_cmd_t c;
        c.mode  = ADJ_NONE;
        c.steps = '0;
        if (w.code != '0) begin
            if (w.remove) begin
                c.mode  = ADJ_DROP;
                c.steps = (~w.code) + CODE_W'(1);
            end else begin
                c.steps = w.code - CODE_W'(1);
                c.mode  = (c.steps == '0) ? ADJ_NONE : ADJ_ADD;
            end
        end
        return c;
    endfunction

    function automatic logic [PEND_W-1:0] pulses_of(input trim_cmd_t c);
        return {c.steps, 1'b0};
    endfunction

endpackage

// File: rtl/trim_word_reg.sv
module trim_word_reg
    import rtc_trim_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_i,
    input  logic       wr_en_i,
    input  trim_word_t wr_word_i,
    input  logic       win_end_i,
    output trim_word_t active_o,
    output trim_word_t next_o,
    output logic       busy_o
);

    trim_word_t pending_q;
    trim_word_t active_q;
    logic       busy_q;

    assign next_o   = busy_q ? pending_q : active_q;
    assign active_o = active_q;
    assign busy_o   = busy_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            pending_q <= '0;
            active_q  <= '0;
            busy_q    <= 1'b0;
        end else begin
            if (win_end_i) begin
                active_q <= next_o;
                busy_q   <= 1'b0;
            end
            if (wr_en_i && !busy_q) begin
                pending_q <= wr_word_i;
                busy_q    <= 1'b1;
            end
        end
    end

    // R6: accepted write raises busy
    p_accept_sets_busy_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        (wr_en_i && !busy_q) |=> busy_q);

    // R6: busy persists until a boundary
    p_busy_hold_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        (busy_q && !win_end_i) |=> busy_q);

    // R6: busy drops after the boundary
    p_busy_clear_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        (busy_q && win_end_i) |=> !busy_q);

    // R6: active trim only moves on a boundary
    p_active_steady_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        !win_end_i |=> $stable(active_q));

    // R7: writes while busy leave the parked word alone
    p_ignore_busy_write_r7: assert property (@(posedge clk_i) disable iff (rst_i)
        (busy_q && wr_en_i) |=> $stable(pending_q));

endmodule

// File: rtl/trim_window_timer.sv
module trim_window_timer #(
    parameter int unsigned SHORT_LEN = 655360,
    parameter int unsigned LONG_LEN  = 1966080,
    parameter int unsigned CNT_W     = $clog2(LONG_LEN)
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic src_pulse_i,
    input  logic long_sel_i,
    output logic win_end_o
);

    localparam logic [CNT_W-1:0] SHORT_LAST = CNT_W'(SHORT_LEN - 1);
    localparam logic [CNT_W-1:0] LONG_LAST  = CNT_W'(LONG_LEN - 1);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] last_idx;

    assign last_idx  = long_sel_i ? LONG_LAST : SHORT_LAST;
    assign win_end_o = src_pulse_i && (cnt_q == last_idx);

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cnt_q <= '0;
        end else if (src_pulse_i) begin
            cnt_q <= win_end_o ? '0 : cnt_q + CNT_W'(1);
        end
    end

    // R2: position never passes the selected window length
    p_cnt_in_window_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        cnt_q <= last_idx);

    // R2: count restarts after every boundary
    p_restart_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        win_end_o |=> (cnt_q == '0));

endmodule

// File: rtl/trim_pulse_adjust.sv
module trim_pulse_adjust
    import rtc_trim_pkg::*;
(
    input  logic      clk_i,
    input  logic      rst_i,
    input  logic      src_pulse_i,
    input  logic      win_end_i,
    input  trim_cmd_t load_cmd_i,
    output logic      tick_nxt_o,
    output logic      tick_o
);

    adj_mode_t         mode_q;
    logic [PEND_W-1:0] rem_q;
    logic              owed;
    logic              tick_q;

    assign owed = (rem_q != '0);

    always_comb begin
        if (src_pulse_i)
            tick_nxt_o = !((mode_q == ADJ_DROP) && owed);
        else
            tick_nxt_o = (mode_q == ADJ_ADD) && owed;
    end

    assign tick_o = tick_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            mode_q <= ADJ_NONE;
            rem_q  <= '0;
            tick_q <= 1'b0;
        end else begin
            tick_q <= tick_nxt_o;
            if (win_end_i) begin
                mode_q <= load_cmd_i.mode;
                rem_q  <= pulses_of(load_cmd_i);
            end else if (owed) begin
                if ((mode_q == ADJ_ADD) && !src_pulse_i)
                    rem_q <= rem_q - PEND_W'(1);
                else if ((mode_q == ADJ_DROP) && src_pulse_i)
                    rem_q <= rem_q - PEND_W'(1);
            end
        end
    end

    // R8: no source and nothing owed means no tick next cycle
    p_no_spurious_tick_r8: assert property (@(posedge clk_i) disable iff (rst_i)
        (!src_pulse_i && !owed) |=> !tick_o);

    // R8: an unaffected source pulse always yields a tick
    p_pulse_passes_r8: assert property (@(posedge clk_i) disable iff (rst_i)
        (src_pulse_i && (mode_q != ADJ_DROP)) |=> tick_o);

    // R9: corrections are exhausted by the boundary
    p_drained_at_end_r9: assert property (@(posedge clk_i) disable iff (rst_i)
        win_end_i |-> !owed);

endmodule

// File: rtl/rtc_trim_unit.sv
module rtc_trim_unit
    import rtc_trim_pkg::*;
#(
    parameter int unsigned PULSES_PER_SEC = 32768,
    parameter int unsigned SHORT_S        = 20,
    parameter int unsigned LONG_S         = 60
) (
    input  logic       clk_i,
    input  logic       rst_i,
    input  logic       src_pulse_i,
    input  logic       wr_en_i,
    input  logic [7:0] wr_data_i,
    output logic       tick_o,
    output logic       busy_o
);

    localparam int unsigned SHORT_LEN = PULSES_PER_SEC * SHORT_S;
    localparam int unsigned LONG_LEN  = PULSES_PER_SEC * LONG_S;
    localparam int unsigned CNT_W     = $clog2(LONG_LEN);
    localparam int unsigned TOT_W     = $clog2(LONG_LEN + 256) + 1;

    trim_word_t active_w;
    trim_word_t next_w;
    trim_cmd_t  next_cmd;
    logic       win_end;
    logic       tick_nxt;

    assign next_cmd = decode_trim(next_w);

    trim_word_reg u_word (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .wr_en_i   (wr_en_i),
        .wr_word_i (trim_word_t'(wr_data_i)),
        .win_end_i (win_end),
        .active_o  (active_w),
        .next_o    (next_w),
        .busy_o    (busy_o)
    );

    trim_window_timer #(
        .SHORT_LEN (SHORT_LEN),
        .LONG_LEN  (LONG_LEN),
        .CNT_W     (CNT_W)
    ) u_timer (
        .clk_i       (clk_i),
        .rst_i       (rst_i),
        .src_pulse_i (src_pulse_i),
        .long_sel_i  (active_w.long_win),
        .win_end_o   (win_end)
    );

    trim_pulse_adjust u_adjust (
        .clk_i       (clk_i),
        .rst_i       (rst_i),
        .src_pulse_i (src_pulse_i),
        .win_end_i   (win_end),
        .load_cmd_i  (next_cmd),
        .tick_nxt_o  (tick_nxt),
        .tick_o      (tick_o)
    );

    // Self-check: ticks per window against length and trim
    logic [TOT_W-1:0] tot_q;
    logic [TOT_W-1:0] tot_expect;
    trim_cmd_t        act_cmd;

    assign act_cmd = decode_trim(active_w);

    always_comb begin
        tot_expect = active_w.long_win ? TOT_W'(LONG_LEN) : TOT_W'(SHORT_LEN);
        if (act_cmd.mode == ADJ_ADD)
            tot_expect = tot_expect + TOT_W'(pulses_of(act_cmd));
        else if (act_cmd.mode == ADJ_DROP)
            tot_expect = tot_expect - TOT_W'(pulses_of(act_cmd));
    end

    always_ff @(posedge clk_i) begin
        if (rst_i)
            tot_q <= '0;
        else if (win_end)
            tot_q <= '0;
        else if (tick_nxt)
            tot_q <= tot_q + TOT_W'(1);
    end

    // R9 with R4 and R5: window tick total matches the trim
    p_window_total_r9: assert property (@(posedge clk_i) disable iff (rst_i)
        win_end |-> ((tot_q + TOT_W'(tick_nxt)) == tot_expect));

    // R1: outputs idle right after reset
    p_reset_idle_r1: assert property (@(posedge clk_i)
        rst_i |=> (!tick_o && !busy_o));

endmodule

// File: tb/rtc_trim_unit_tb_top.sv
module rtc_trim_unit_tb_top;

    localparam int unsigned PPS     = 8;
    localparam int unsigned SHORT_S = 20;
    localparam int unsigned LONG_S  = 60;
    localparam int unsigned SLEN    = PPS * SHORT_S;
    localparam int unsigned LLEN    = PPS * LONG_S;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       src = 1'b0;
    logic       we  = 1'b0;
    logic [7:0] wd  = 8'h00;
    logic       tick;
    logic       busy;

    int checks   = 0;
    int fails    = 0;
    int tick_cnt = 0;
    int mark     = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;

    rtc_trim_unit #(
        .PULSES_PER_SEC (PPS),
        .SHORT_S        (SHORT_S),
        .LONG_S         (LONG_S)
    ) dut_i (
        .clk_i       (clk),
        .rst_i       (rst),
        .src_pulse_i (src),
        .wr_en_i     (we),
        .wr_data_i   (wd),
        .tick_o      (tick),
        .busy_o      (busy)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step(input logic s, input logic w, input logic [7:0] d, output logic t);
        @(negedge clk);
        t = tick;
        if (t) tick_cnt++;
        src = s;
        we  = w;
        wd  = d;
    endtask

    // Drive one window; mark ticks up to the boundary pulse's tick.
    task automatic run_window(input int pulses, input int expect_ticks,
                              input string req, input bit align);
        logic t;
        int   bad = 0;
        for (int p = 0; p < pulses; p++) begin
            step(1'b1, 1'b0, 8'h00, t);
            if (align && p > 0 && t) bad++;
            step(1'b0, 1'b0, 8'h00, t);
            if (align && !t) bad++;
            if (p == pulses - 1) begin
                check((tick_cnt - mark) == expect_ticks, req, tick_cnt - mark, expect_ticks);
                mark = tick_cnt;
            end
            step(1'b0, 1'b0, 8'h00, t);
            if (align && t) bad++;
            step(1'b0, 1'b0, 8'h00, t);
            if (align && t) bad++;
        end
        if (align) check(bad == 0, "R8 tick alignment", bad, 0);
    endtask

    task automatic write_word(input logic [7:0] d, input bit expect_busy_before);
        logic t;
        check(busy == expect_busy_before, "R6 busy before write", busy, expect_busy_before);
        step(1'b0, 1'b1, d, t);
        step(1'b0, 1'b0, 8'h00, t);
        check(busy == 1'b1, "R6 busy after write", busy, 1);
    endtask

    task automatic test_reset;
        logic t;
        rst = 1'b1;
        repeat (4) step(1'b0, 1'b0, 8'h00, t);
        check(tick == 1'b0, "R1 tick in reset", tick, 0);
        check(busy == 1'b0, "R1 busy in reset", busy, 0);
        rst = 1'b0;
        step(1'b0, 1'b0, 8'h00, t);
        check(busy == 1'b0 && tick == 1'b0, "R1 idle after reset", busy, 0);
        tick_cnt = 0;
        mark     = 0;
    endtask

    task automatic test_no_trim;
        // R2 R3 R8: short window, no correction, one tick per pulse
        run_window(SLEN, SLEN, "R3 zero trim short window", 1'b1);
    endtask

    task automatic test_add_and_ignore;
        // R6 R7: 0x05 accepted, 0xC1 discarded while busy
        write_word(8'h05, 1'b0);
        write_word(8'hC1, 1'b1);
        run_window(SLEN, SLEN, "R6 old trim still active", 1'b0);
        check(busy == 1'b0, "R6 busy cleared at boundary", busy, 0);
        // R4 and R7: 4 steps add 8 ticks; discarded word had no effect
        run_window(SLEN, SLEN + 8, "R4 R7 add code 5", 1'b0);
    endtask

    task automatic test_remove_small;
        write_word(8'h7E, 1'b0);
        run_window(SLEN, SLEN + 8, "R6 previous add persists", 1'b0);
        // R5: code 62 inverted is 1, plus one gives 2 steps
        run_window(SLEN, SLEN - 4, "R5 remove code 62", 1'b0);
    endtask

    task automatic test_remove_max;
        write_word(8'h41, 1'b0);
        run_window(SLEN, SLEN - 4, "R6 previous remove persists", 1'b0);
        // R5: code 1 removes 63 steps
        run_window(SLEN, SLEN - 126, "R5 remove code 1", 1'b0);
    endtask

    task automatic test_long_add_max;
        write_word(8'hBF, 1'b0);
        run_window(SLEN, SLEN - 126, "R6 short window before switch", 1'b0);
        // R2 R4: long window, code 63 adds 124
        run_window(LLEN, LLEN + 124, "R4 R2 long add code 63", 1'b0);
    endtask

    task automatic test_zero_codes;
        write_word(8'hC0, 1'b0);
        run_window(LLEN, LLEN + 124, "R6 long add persists", 1'b0);
        // R3: remove with code 0 is no correction
        run_window(LLEN, LLEN, "R3 long remove code 0", 1'b1);
        write_word(8'h01, 1'b0);
        run_window(LLEN, LLEN, "R2 long window before switch back", 1'b0);
        // R4: add code 1 is zero steps, back to short window
        run_window(SLEN, SLEN, "R4 add code 1", 1'b0);
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        test_reset();
        test_no_trim();
        test_add_and_ignore();
        test_remove_small();
        test_remove_max();
        test_long_add_max();
        test_zero_codes();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule